// File: doc/BRIEF.md
# Quad-Enable Bit Setter for Serial NOR Flash

This block turns on one configuration bit, normally the quad-enable bit, in the status registers of a serial NOR flash. It does this through a command port to a single-line SPI master. A caller pulses `start` with a 4-bit bit index and a write-style select. The block first reads the addressed status register. If the bit is already 1, it stops there and writes nothing. If the bit is 0, it sends write-enable, writes the register back with the bit set, and polls the busy flag until the flash finishes or a poll budget runs out.

Two write styles are supported. In per-register style the chosen register is written alone with its own one-byte command. In combined style the other status register is read as well, and both bytes go out in a single two-byte write. Register 0's byte is sent first, and the register that is not being changed keeps its value. The SPI shifter is outside this block. The block only sequences commands, and each command is held on the port until the master signals completion.

Top module: `qe_setter`

## Requirements
- R1: While reset is applied and after it is released, `cmdValid`, `done` and `errCode` are 0.
- R2: `bitIdx[3]` selects status register 0 or 1 and `bitIdx[2:0]` selects the bit in it. The first command after `start` reads that register: opcode 0x05 for register 0, 0x35 for register 1, `cmdTxLen`=0, `cmdRxLen`=1, `cmdTxData`=0.
- R3: If the target bit in the returned byte is already 1, the block completes with `errCode`=0 and issues no further command.
- R4: Every status write is immediately preceded by a write-enable command: opcode 0x06, `cmdTxLen`=0, `cmdRxLen`=0, `cmdTxData`=0.
- R5: With `combined`=0, the write uses opcode 0x01 (register 0) or 0x31 (register 1) with `cmdTxLen`=1. `cmdTxData[15:8]` carries the byte that was read with the target bit set, and `cmdTxData[7:0]`=0.
- R6: With `combined`=1, after the target read the block reads the other register (0x35 when the target is register 0, else 0x05). It then writes opcode 0x01 with `cmdTxLen`=2: register 0's byte in `cmdTxData[15:8]` (sent first) and register 1's byte in `cmdTxData[7:0]`. The target byte has its bit set and the other byte is unchanged.
- R7: After the write, the block polls with opcode 0x05 (`cmdRxLen`=1). It completes with `errCode`=0 on the first poll whose returned bit 0 is 0. After a busy poll, `cmdValid` stays low for exactly `POLL_GAP` cycles before the next poll.
- R8: If `POLL_LIMIT` polls all return bit 0 = 1, the block completes with `errCode`=2 (busy timeout) and issues no further command.
- R9: A command that completes with `cmdFail`=1 ends the sequence with `errCode`=1 and no further command.
- R10: A command stays asserted with stable fields until the cycle `cmdDone` is seen. `start` has no effect while a sequence is running.
- R11: `done` is a one-cycle pulse. `errCode` is valid with it and holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sequence (accepted when idle) |
| bitIdx | input | 4 | Register select (bit 3) and bit position (bits 2:0) |
| combined | input | 1 | 1: single two-byte write; 0: per-register write |
| cmdValid | output | 1 | Command request to the SPI master, held until done |
| cmdOpcode | output | 8 | Command opcode |
| cmdTxLen | output | 2 | Number of data bytes to send |
| cmdRxLen | output | 1 | Number of bytes to receive (0 or 1) |
| cmdTxData | output | 16 | Transmit bytes, first byte in [15:8] |
| cmdDone | input | 1 | Master finished the current command (one cycle) |
| cmdFail | input | 1 | Master reports failure, valid with cmdDone |
| cmdRxData | input | 8 | Received byte, valid with cmdDone |
| done | output | 1 | Sequence complete pulse |
| errCode | output | 2 | 0 ok, 1 command failure, 2 busy timeout |

## Verification
The assertions assume that the SPI master raises `cmdDone` only while `cmdValid` is high. They also assume that `cmdDone` lasts one cycle and that `cmdFail` and `cmdRxData` are meaningful only alongside it. The bench's responder model follows these rules: it latches a request, waits a fixed latency, and pulses `cmdDone` once before accepting the next request. Stimulus keeps the target bit away from position 0 of register 0, so the busy flag and the target bit never coincide. It also varies register selection, write style, preset bit values, busy lengths and the point at which a failure is injected.

// File: rtl/qe_pkg.sv
package qe_pkg;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDSR0 = 8'h05;
  localparam logic [7:0] OP_RDSR1 = 8'h35;
  localparam logic [7:0] OP_WRSR0 = 8'h01;
  localparam logic [7:0] OP_WRSR1 = 8'h31;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_RD_TGT,
    CK_RD_OTH,
    CK_WREN,
    CK_WRITE,
    CK_POLL
  } cmdKind_t;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_BUS     = 2'd1,
    ERR_TIMEOUT = 2'd2
  } errCode_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic     latchReq;
    logic     capTarget;
    logic     capOther;
    logic     incPoll;
    logic     loadGap;
    logic     decGap;
    logic     finish;
    errCode_t finCode;
    cmdKind_t kind;
  } qeStrobe_t;

endpackage

// File: rtl/qe_ctrl.sv
module qe_ctrl
  import qe_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      useComb,
  input  logic      rxHasBit,
  input  logic      rxBusy,
  input  logic      pollLast,
  input  logic      gapZero,
  input  logic      cmdDone,
  input  logic      cmdFail,
  output logic      cmdValid,
  output qeStrobe_t strb
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_TGT,
    ST_RD_OTH,
    ST_WREN,
    ST_WRITE,
    ST_POLL,
    ST_GAP
  } state_t;

  state_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb      = '0;
    stateNext = state;
    cmdValid  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strb.latchReq = 1'b1;
          stateNext     = ST_RD_TGT;
        end
      end
      ST_RD_TGT: begin
        cmdValid  = 1'b1;
        strb.kind = CK_RD_TGT;
        if (cmdDone) begin
          if (cmdFail) begin
            strb.finish  = 1'b1;
            strb.finCode = ERR_BUS;
            stateNext    = ST_IDLE;
          end else if (rxHasBit) begin
            strb.finish  = 1'b1;
            strb.finCode = ERR_NONE;
            stateNext    = ST_IDLE;
          end else begin
            strb.capTarget = 1'b1;
            stateNext      = useComb ? ST_RD_OTH : ST_WREN;
          end
        end
      end
      ST_RD_OTH: begin
        cmdValid  = 1'b1;
        strb.kind = CK_RD_OTH;
        if (cmdDone) begin
          if (cmdFail) begin
            strb.finish  = 1'b1;
            strb.finCode = ERR_BUS;
            stateNext    = ST_IDLE;
          end else begin
            strb.capOther = 1'b1;
            stateNext     = ST_WREN;
          end
        end
      end
      ST_WREN: begin
        cmdValid  = 1'b1;
        strb.kind = CK_WREN;
        if (cmdDone) begin
          if (cmdFail) begin
            strb.finish  = 1'b1;
            strb.finCode = ERR_BUS;
            stateNext    = ST_IDLE;
          end else begin
            stateNext = ST_WRITE;
          end
        end
      end
      ST_WRITE: begin
        cmdValid  = 1'b1;
        strb.kind = CK_WRITE;
        if (cmdDone) begin
          if (cmdFail) begin
            strb.finish  = 1'b1;
            strb.finCode = ERR_BUS;
            stateNext    = ST_IDLE;
          end else begin
            stateNext = ST_POLL;
          end
        end
      end
      ST_POLL: begin
        cmdValid  = 1'b1;
        strb.kind = CK_POLL;
        if (cmdDone) begin
          if (cmdFail) begin
            strb.finish  = 1'b1;
            strb.finCode = ERR_BUS;
            stateNext    = ST_IDLE;
          end else if (!rxBusy) begin
            strb.finish  = 1'b1;
            strb.finCode = ERR_NONE;
            stateNext    = ST_IDLE;
          end else if (pollLast) begin
            strb.finish  = 1'b1;
            strb.finCode = ERR_TIMEOUT;
            stateNext    = ST_IDLE;
          end else begin
            strb.incPoll = 1'b1;
            strb.loadGap = 1'b1;
            stateNext    = ST_GAP;
          end
        end
      end
      ST_GAP: begin
        if (gapZero) stateNext = ST_POLL;
        else         strb.decGap = 1'b1;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdDone) |=> (cmdValid && $stable(strb.kind))); // R10

  AST_DONE_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cmdDone |-> cmdValid); // R10

  AST_WREN_BEFORE_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WRITE && $past(state) != ST_WRITE) |-> ($past(state) == ST_WREN)); // R4

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strb.latchReq); // R10

endmodule

// File: rtl/qe_dpath.sv
module qe_dpath
  import qe_pkg::*;
#(
  parameter int POLL_LIMIT = 10000,
  parameter int POLL_GAP   = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  qeStrobe_t   strb,
  input  logic [3:0]  bitIdx,
  input  logic        combined,
  input  logic [7:0]  cmdRxData,
  output logic [7:0]  cmdOpcode,
  output logic [1:0]  cmdTxLen,
  output logic        cmdRxLen,
  output logic [15:0] cmdTxData,
  output logic        useComb,
  output logic        rxHasBit,
  output logic        rxBusy,
  output logic        pollLast,
  output logic        gapZero,
  output logic        done,
  output logic [1:0]  errCode
);

  localparam int PCNT_W = (POLL_LIMIT > 1) ? $clog2(POLL_LIMIT) : 1;
  localparam int GCNT_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;

  logic              regSel;
  logic [2:0]        bitPos;
  logic [7:0]        tgtByte;
  logic [7:0]        othByte;
  logic [PCNT_W-1:0] pollCnt;
  logic [GCNT_W-1:0] gapCnt;
  logic [7:0]        bitMask;
  logic [7:0]        newTgt;
  logic [7:0]        reg0Byte;
  logic [7:0]        reg1Byte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regSel  <= 1'b0;
      bitPos  <= '0;
      useComb <= 1'b0;
      tgtByte <= '0;
      othByte <= '0;
      pollCnt <= '0;
      gapCnt  <= '0;
      done    <= 1'b0;
      errCode <= ERR_NONE;
    end else begin
      done <= strb.finish;
      if (strb.latchReq) begin
        regSel  <= bitIdx[3];
        bitPos  <= bitIdx[2:0];
        useComb <= combined;
        pollCnt <= '0;
        errCode <= ERR_NONE;
      end
      if (strb.capTarget) tgtByte <= cmdRxData;
      if (strb.capOther)  othByte <= cmdRxData;
      if (strb.incPoll)   pollCnt <= pollCnt + 1'b1;
      if (strb.loadGap)   gapCnt  <= GCNT_W'(POLL_GAP - 1);
      else if (strb.decGap) gapCnt <= gapCnt - 1'b1;
      if (strb.finish)    errCode <= strb.finCode;
    end
  end

  assign bitMask  = 8'h01 << bitPos;
  assign rxHasBit = |(cmdRxData & bitMask);
  assign rxBusy   = cmdRxData[0];
  assign pollLast = (pollCnt == PCNT_W'(POLL_LIMIT - 1));
  assign gapZero  = (gapCnt == '0);
  assign newTgt   = tgtByte | bitMask;
  assign reg0Byte = regSel ? othByte : newTgt;
  assign reg1Byte = regSel ? newTgt : othByte;

  always_comb begin
    cmdOpcode = 8'h00;
    cmdTxLen  = 2'd0;
    cmdRxLen  = 1'b0;
    cmdTxData = 16'h0000;
    unique case (strb.kind)
      CK_RD_TGT: begin
        cmdOpcode = regSel ? OP_RDSR1 : OP_RDSR0;
        cmdRxLen  = 1'b1;
      end
      CK_RD_OTH: begin
        cmdOpcode = regSel ? OP_RDSR0 : OP_RDSR1;
        cmdRxLen  = 1'b1;
      end
      CK_WREN: cmdOpcode = OP_WREN;
      CK_WRITE: begin
        if (useComb) begin
          cmdOpcode = OP_WRSR0;
          cmdTxLen  = 2'd2;
          cmdTxData = {reg0Byte, reg1Byte};
        end else begin
          cmdOpcode = regSel ? OP_WRSR1 : OP_WRSR0;
          cmdTxLen  = 2'd1;
          cmdTxData = {newTgt, 8'h00};
        end
      end
      CK_POLL: begin
        cmdOpcode = OP_RDSR0;
        cmdRxLen  = 1'b1;
      end
      default: ;
    endcase
  end

  AST_POLL_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt <= PCNT_W'(POLL_LIMIT - 1)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_ERR_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    errCode != 2'd3); // R11

  AST_ERR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.latchReq && !strb.finish) |=> $stable(errCode)); // R11

endmodule

// File: rtl/qe_setter.sv
module qe_setter
  import qe_pkg::*;
#(
  parameter int POLL_LIMIT = 10000,
  parameter int POLL_GAP   = 250
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [3:0]  bitIdx,
  input  logic        combined,
  output logic        cmdValid,
  output logic [7:0]  cmdOpcode,
  output logic [1:0]  cmdTxLen,
  output logic        cmdRxLen,
  output logic [15:0] cmdTxData,
  input  logic        cmdDone,
  input  logic        cmdFail,
  input  logic [7:0]  cmdRxData,
  output logic        done,
  output logic [1:0]  errCode
);

  qeStrobe_t strb;
  logic      useComb;
  logic      rxHasBit;
  logic      rxBusy;
  logic      pollLast;
  logic      gapZero;

  qe_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .useComb  (useComb),
    .rxHasBit (rxHasBit),
    .rxBusy   (rxBusy),
    .pollLast (pollLast),
    .gapZero  (gapZero),
    .cmdDone  (cmdDone),
    .cmdFail  (cmdFail),
    .cmdValid (cmdValid),
    .strb     (strb)
  );

  qe_dpath #(
    .POLL_LIMIT (POLL_LIMIT),
    .POLL_GAP   (POLL_GAP)
  ) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .bitIdx    (bitIdx),
    .combined  (combined),
    .cmdRxData (cmdRxData),
    .cmdOpcode (cmdOpcode),
    .cmdTxLen  (cmdTxLen),
    .cmdRxLen  (cmdRxLen),
    .cmdTxData (cmdTxData),
    .useComb   (useComb),
    .rxHasBit  (rxHasBit),
    .rxBusy    (rxBusy),
    .pollLast  (pollLast),
    .gapZero   (gapZero),
    .done      (done),
    .errCode   (errCode)
  );

endmodule

// File: tb/tb_qe_setter.sv
module tb_qe_setter;

  localparam int LIMIT = 5;
  localparam int GAP   = 3;
  localparam int LAT   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  bitIdx = 4'h0;
  logic        combined = 1'b0;
  logic        cmdDone = 1'b0;
  logic        cmdFail = 1'b0;
  logic [7:0]  cmdRxData = 8'h00;
  logic        cmdValid;
  logic [7:0]  cmdOpcode;
  logic [1:0]  cmdTxLen;
  logic        cmdRxLen;
  logic [15:0] cmdTxData;
  logic        done;
  logic [1:0]  errCode;

  qe_setter #(.POLL_LIMIT(LIMIT), .POLL_GAP(GAP)) dut (
    .clk(clk), .rstN(rstN), .start(start), .bitIdx(bitIdx), .combined(combined),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdTxLen(cmdTxLen),
    .cmdRxLen(cmdRxLen), .cmdTxData(cmdTxData), .cmdDone(cmdDone),
    .cmdFail(cmdFail), .cmdRxData(cmdRxData), .done(done), .errCode(errCode)
  );

  always #2 clk = ~clk;

  int nRun = 0;
  int nFail = 0;
  int cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // flash and responder model state
  logic [7:0]  sr0, sr1;
  int          busyLeft, failAt, cmdIdx, lat, refCyc;
  bit          wrote, pend, holdOk, lastWasPoll;
  logic [26:0] cur;
  logic [26:0] expQ[$];
  string       tagQ[$];
  string       endTag = "R3";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rdOp(input bit r);
    return r ? 8'h35 : 8'h05;
  endfunction

  always @(negedge clk) begin
    if (!rstN) begin
      pend = 0;
      cmdDone = 0;
      cmdFail = 0;
    end else begin
      cmdDone = 0;
      cmdFail = 0;
      if (pend) begin
        if (!cmdValid || {cmdOpcode, cmdTxLen, cmdRxLen, cmdTxData} != cur) holdOk = 0;
        if (lat == 0) begin
          cmdDone = 1;
          cmdRxData = 8'h00;
          lastWasPoll = 0;
          if (cmdIdx - 1 == failAt) cmdFail = 1;
          else begin
            case (cur[26:19])
              8'h05: begin
                cmdRxData = sr0 | {7'd0, (wrote && busyLeft > 0)};
                lastWasPoll = wrote;
                if (wrote && busyLeft > 0) busyLeft--;
              end
              8'h35: cmdRxData = sr1;
              8'h01: begin
                if (cur[18:17] == 2'd2) {sr0, sr1} = cur[15:0];
                else sr0 = cur[15:8];
                wrote = 1;
              end
              8'h31: begin sr1 = cur[15:8]; wrote = 1; end
              default: ;
            endcase
          end
          check(holdOk, "R10", "command held until done", 0, 0);
          refCyc = cyc;
          pend = 0;
        end else lat--;
      end else if (cmdValid) begin
        cur = {cmdOpcode, cmdTxLen, cmdRxLen, cmdTxData};
        holdOk = 1;
        pend = 1;
        lat = LAT;
        cmdIdx++;
        if (expQ.size() == 0) check(0, endTag, "unexpected command", cur, 0);
        else begin
          logic [26:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check(cur == e, t, "command fields", cur, e);
          if (lastWasPoll) check(cyc - refCyc == GAP + 1, "R7", "poll spacing",
                                 cyc - refCyc, GAP + 1);
        end
      end
    end
  end

  task automatic runCase(input logic [3:0] idx, input bit comb, input logic [7:0] s0,
                         input logic [7:0] s1, input int busy, input int fail,
                         input string tg, input bit midStart);
    bit tgt;
    logic [7:0] tv, msk, nv;
    int expErr, n, w;
    sr0 = s0; sr1 = s1; busyLeft = busy; wrote = 0; failAt = fail;
    cmdIdx = 0; lastWasPoll = 0; endTag = tg;
    expQ.delete(); tagQ.delete();
    tgt = idx[3];
    msk = 8'h01 << idx[2:0];
    tv = tgt ? s1 : s0;
    expErr = 0;
    expQ.push_back({rdOp(tgt), 2'd0, 1'b1, 16'h0}); tagQ.push_back("R2");
    if ((tv & msk) == 0) begin
      if (comb) begin expQ.push_back({rdOp(!tgt), 2'd0, 1'b1, 16'h0}); tagQ.push_back("R6"); end
      expQ.push_back({8'h06, 2'd0, 1'b0, 16'h0}); tagQ.push_back("R4");
      nv = tv | msk;
      if (comb) begin
        expQ.push_back({8'h01, 2'd2, 1'b0, (tgt ? {s0, nv} : {nv, s1})}); tagQ.push_back("R6");
      end else begin
        expQ.push_back({(tgt ? 8'h31 : 8'h01), 2'd1, 1'b0, {nv, 8'h00}}); tagQ.push_back("R5");
      end
      n = (busy >= LIMIT) ? LIMIT : busy + 1;
      for (int k = 0; k < n; k++) begin
        expQ.push_back({8'h05, 2'd0, 1'b1, 16'h0}); tagQ.push_back(busy >= LIMIT ? "R8" : "R7");
      end
      expErr = (busy >= LIMIT) ? 2 : 0;
    end
    if (fail >= 0 && fail < expQ.size()) begin
      while (expQ.size() > fail + 1) begin void'(expQ.pop_back()); void'(tagQ.pop_back()); end
      expErr = 1;
    end
    @(negedge clk);
    bitIdx = idx; combined = comb; start = 1;
    @(negedge clk);
    start = 0;
    w = 0;
    while (!done && w < 3000) begin
      @(negedge clk);
      w++;
      if (midStart && w == 4) begin bitIdx = 4'h2; combined = !comb; start = 1; end
      else start = 0;
    end
    start = 0;
    if (!done) check(0, "R11", "watchdog: no done", 0, 1);
    else begin
      check(errCode == expErr[1:0], tg, "errCode at done", errCode, expErr);
      check(expQ.size() == 0, tg, "missing commands", expQ.size(), 0);
      @(negedge clk);
      check(!done, "R11", "done pulse width", done, 0);
      check(errCode == expErr[1:0], "R11", "errCode held", errCode, expErr);
    end
    repeat (12) @(negedge clk);
    check(!cmdValid, tg, "quiet after sequence", cmdValid, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nFail++;
      $display("FAIL R11 global watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmdValid == 0 && done == 0 && errCode == 0, "R1", "outputs in reset",
          {cmdValid, done, errCode}, 0);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(cmdValid == 0 && done == 0 && errCode == 0, "R1", "outputs after reset",
          {cmdValid, done, errCode}, 0);

    runCase(4'h9, 0, 8'h00, 8'h02, 0, -1, "R3", 0);  // R3 already set, reg 1
    runCase(4'h9, 0, 8'h00, 8'h00, 2, -1, "R7", 1);  // R5 R7 R10 per-register reg 1
    runCase(4'h3, 0, 8'h40, 8'h00, 1, -1, "R7", 0);  // R2 R5 reg 0 bit 3
    runCase(4'h9, 1, 8'h1C, 8'h40, 0, -1, "R7", 0);  // R6 combined, target reg 1
    runCase(4'h4, 1, 8'h80, 8'h01, 3, -1, "R7", 0);  // R6 combined, target reg 0
    runCase(4'hF, 0, 8'h00, 8'h11, 0, -1, "R7", 0);  // R5 reg 1 bit 7
    runCase(4'h9, 1, 8'h00, 8'h02, 0, -1, "R3", 0);  // R3 combined already set
    runCase(4'h9, 0, 8'h00, 8'h00, 100, -1, "R8", 0); // R8 busy timeout
    runCase(4'h9, 0, 8'h00, 8'h00, 0, 1, "R9", 0);   // R9 fail on write enable
    runCase(4'h2, 1, 8'h00, 8'h00, 4, 5, "R9", 0);   // R9 fail on a poll
    runCase(4'hA, 0, 8'h00, 8'h00, 0, 0, "R9", 0);   // R9 fail on first read

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule